// File: doc/BRIEF.md
# Page Translation Cache with Directory-Base Flush

This block keeps a handful of recent linear-to-physical page translations so that most memory accesses skip the slow table walk. Each lookup presents a 32-bit linear address, the access mode (user or kernel) and the access type (read or write). One cycle later the block reports exactly one of three outcomes. A hit returns the physical address. A protection fault means the page is cached but the access is not allowed. A miss means a table walk is needed. After a miss the block waits for the walker to return the translation and stores it in a free or round-robin slot.

Every slot can hold either a small (4 KB) or a large (4 MB) page, together with a user-access flag and a write-enable flag. Any write to the page directory base register drops every cached translation in the same cycle. A flush outranks a fill that arrives in the same cycle.

The controller has two states. `ST_READY` accepts lookups. `ST_WAIT` holds while a walk is outstanding and ignores lookups. Transition `miss_seen` (`ST_READY` to `ST_WAIT`) is taken when an accepted lookup misses. Transition `walk_done` (`ST_WAIT` to `ST_READY`) is taken on any cycle with `fill_valid`, whether the fill is stored or discarded by a flush.

Top module: `xlate_cache`

## Requirements
- R1: After reset all slots are invalid, `rdy` is 1 and `res_valid` is 0, so the first lookup reports a miss.
- R2: A lookup accepted on a clock edge (`lk_valid` high, `rdy` high) yields `res_valid`=1 for exactly one cycle after that edge, with exactly one of `res_hit`, `res_fault`, `res_miss` set; when `res_valid` is 0 all three flags are 0.
- R3: A small-page slot (`fill_big`=0) matches when linear bits 31:12 equal its stored page number; the result is `{pfn, vaddr[11:0]}`.
- R4: A large-page slot (`fill_big`=1) matches when linear bits 31:22 equal bits 19:10 of its stored page number; the result is `{pfn[19:10], vaddr[21:0]}`; bits 9:0 of the filled page and frame numbers have no effect.
- R5: A matching lookup faults when `lk_user`=1 and the slot's user flag is 0, or when `lk_write`=1 and the slot's write flag is 0; a fault starts no walk and `rdy` stays 1.
- R6: A miss moves the controller to `ST_WAIT` (`rdy`=0); lookups there give no result; any `fill_valid` returns it to `ST_READY`.
- R7: `base_wr` invalidates every slot at that edge; a lookup presented in the same cycle reports a miss.
- R8: A fill in the same cycle as `base_wr` is discarded, although it still completes the outstanding walk.
- R9: A fill goes to the lowest-numbered invalid slot. When every slot is valid it goes to the slot named by a round-robin pointer, which then advances by one (wrapping). The pointer is 0 after reset and after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Linear address to translate |
| lk_user | input | 1 | 1 = user-mode access |
| lk_write | input | 1 | 1 = write access |
| rdy | output | 1 | 1 in `ST_READY` (lookups accepted) |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Translation found and allowed |
| res_miss | output | 1 | Walk needed |
| res_fault | output | 1 | Translation found, access denied |
| res_paddr | output | 32 | Physical address on a hit |
| fill_valid | input | 1 | Walker returns a translation |
| fill_vpn | input | 20 | Linear page number (bits 31:12) |
| fill_pfn | input | 20 | Physical frame number (bits 31:12) |
| fill_big | input | 1 | 1 = 4 MB page |
| fill_usr | input | 1 | 1 = user accesses allowed |
| fill_wr | input | 1 | 1 = writes allowed |
| base_wr | input | 1 | Directory base register written: flush all |

## Verification
The table pass fills one large page and three small pages with different permission flags. It then looks up addresses at the low and high ends of each page, in both access modes and with both access types. This separates a wrong tag width, a wrong offset merge for large pages and a wrong permission rule. A chain of fills into a full cache, each followed by lookups of the newest and the evicted page, shows which slot the round-robin pointer picked. Directed cases then cover a lookup during a walk, a flush alone, a flush together with a lookup, a flush together with a fill, and the invalid-first rule with the pointer reset after a flush.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int ADDR_W  = 32;
    localparam int SMALL_SH = 12;
    localparam int LARGE_SH = 22;
    localparam int PN_W    = ADDR_W - SMALL_SH;
    localparam int LTAG_W  = ADDR_W - LARGE_SH;

    typedef struct packed {
        logic            valid;
        logic            big;
        logic            usr;
        logic            wr;
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] pfn;
    } slot_t;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_WAIT  = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/xlate_store.sv
module xlate_store #(
    parameter int ENTRIES = 4,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 flush,
    input  logic                                 fill_we,
    input  logic [IDX_W-1:0]                     fill_idx,
    input  xlate_pkg::slot_t                     fill_slot,
    output xlate_pkg::slot_t [ENTRIES-1:0]       slots,
    output logic [ENTRIES-1:0]                   vld
);
    xlate_pkg::slot_t [ENTRIES-1:0] slot_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (flush) begin
                slot_q[g].valid <= 1'b0;
            end else if (fill_we && fill_idx == IDX_W'(g)) begin
                slot_q[g] <= fill_slot;
            end
        end
        assign vld[g] = slot_q[g].valid;
    end

    assign slots = slot_q;

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));

    p_fill_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fill_we) |=> !(|vld));
endmodule

// File: rtl/xlate_match.sv
module xlate_match #(
    parameter int ENTRIES = 4
) (
    input  xlate_pkg::slot_t [ENTRIES-1:0]       slots,
    input  logic [xlate_pkg::ADDR_W-1:0]         vaddr,
    output logic                                 any_hit,
    output xlate_pkg::slot_t                     hit_slot
);
    import xlate_pkg::*;
    localparam int LOW_SKIP = LARGE_SH - SMALL_SH;

    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic tag_ok;
        always_comb begin
            if (slots[g].big)
                tag_ok = (slots[g].vpn[PN_W-1:LOW_SKIP] == vaddr[ADDR_W-1:LARGE_SH]);
            else
                tag_ok = (slots[g].vpn == vaddr[ADDR_W-1:SMALL_SH]);
        end
        assign hit_vec[g] = slots[g].valid && tag_ok;
    end

    always_comb begin
        hit_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_slot = slots[i];
        end
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int ENTRIES = 4,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fill_we,
    input  logic [ENTRIES-1:0] vld,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] ptr_q;
    logic             full;

    assign full = &vld;

    always_comb begin
        idx = ptr_q;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            ptr_q <= '0;
        else if (fill_we && full)
            ptr_q <= ptr_q + 1'b1;
    end

    p_rr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && full && !flush) |=> (ptr_q == $past(ptr_q) + 1'b1));

    p_rr_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_q == '0));
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
    parameter int ENTRIES = 4,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    input  logic        lk_user,
    input  logic        lk_write,
    output logic        rdy,
    output logic        res_valid,
    output logic        res_hit,
    output logic        res_miss,
    output logic        res_fault,
    output logic [31:0] res_paddr,
    input  logic        fill_valid,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_pfn,
    input  logic        fill_big,
    input  logic        fill_usr,
    input  logic        fill_wr,
    input  logic        base_wr
);
    import xlate_pkg::*;

    ctl_state_e          st_q, st_d;
    slot_t [ENTRIES-1:0] slots;
    logic [ENTRIES-1:0]  vld;
    logic [IDX_W-1:0]    fill_idx;
    slot_t               fill_slot, hit_slot;
    logic                any_hit, accept, dec_hit, dec_fault, dec_miss;
    logic [31:0]         dec_paddr;

    assign fill_slot = '{valid: 1'b1, big: fill_big, usr: fill_usr,
                         wr: fill_wr, vpn: fill_vpn, pfn: fill_pfn};

    xlate_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(base_wr), .fill_we(fill_valid),
        .fill_idx(fill_idx), .fill_slot(fill_slot), .slots(slots), .vld(vld));

    xlate_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(base_wr), .fill_we(fill_valid),
        .vld(vld), .idx(fill_idx));

    xlate_match #(.ENTRIES(ENTRIES)) u_match (
        .slots(slots), .vaddr(lk_vaddr), .any_hit(any_hit), .hit_slot(hit_slot));

    // Lookup decision: flush in the same cycle forces a miss.
    always_comb begin
        accept    = lk_valid && (st_q == ST_READY);
        dec_miss  = accept && (!any_hit || base_wr);
        dec_fault = accept && !dec_miss &&
                    ((lk_user && !hit_slot.usr) || (lk_write && !hit_slot.wr));
        dec_hit   = accept && !dec_miss && !dec_fault;
        if (hit_slot.big)
            dec_paddr = {hit_slot.pfn[PN_W-1:LARGE_SH-SMALL_SH], lk_vaddr[LARGE_SH-1:0]};
        else
            dec_paddr = {hit_slot.pfn, lk_vaddr[SMALL_SH-1:0]};
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY: if (dec_miss)   st_d = ST_WAIT;   // miss_seen
            ST_WAIT:  if (fill_valid) st_d = ST_READY;  // walk_done
            default:                  st_d = ST_READY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_d;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_fault <= 1'b0;
            res_paddr <= '0;
        end else begin
            res_valid <= accept;
            res_hit   <= dec_hit;
            res_miss  <= dec_miss;
            res_fault <= dec_fault;
            res_paddr <= dec_hit ? dec_paddr : '0;
        end
    end

    assign rdy = (st_q == ST_READY);

    p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_hit, res_miss, res_fault}) == 1));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss || res_fault));

    p_miss_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (st_q == ST_WAIT));

    p_wait_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |=> !res_valid);

    p_fault_no_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (st_q == ST_READY));
endmodule

// File: tb/xlate_cache_test.sv
`timescale 1ns/1ps
module xlate_cache_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0, lk_user = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic rdy, res_valid, res_hit, res_miss, res_fault;
    logic [31:0] res_paddr;
    logic fill_valid = 1'b0, fill_big = 1'b0, fill_usr = 1'b0, fill_wr = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic base_wr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xlate_cache uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_user(lk_user), .lk_write(lk_write), .rdy(rdy), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
        .res_paddr(res_paddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_big(fill_big), .fill_usr(fill_usr),
        .fill_wr(fill_wr), .base_wr(base_wr));

    // Outcome codes: 0 hit, 1 fault, 2 miss, 3 no result, 4 malformed.
    localparam int K_HIT = 0, K_FLT = 1, K_MISS = 2, K_NONE = 3;

    localparam logic [31:0] T_VA [8] = '{32'h12345ABC, 32'h12345000, 32'h30032101,
        32'h303FFFFF, 32'h30000000, 32'h00400123, 32'h00400123, 32'hFFFFFFFF};
    localparam logic T_USR [8] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic T_WR  [8] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam int   T_K   [8] = '{K_HIT, K_HIT, K_HIT, K_HIT, K_FLT, K_HIT, K_FLT, K_HIT};
    localparam logic [31:0] T_PA [8] = '{32'hABCDEABC, 32'hABCDE000, 32'h15432101,
        32'h157FFFFF, 32'h0, 32'h00777123, 32'h0, 32'h00001FFF};
    localparam string T_REQ [8] = '{"R3", "R3", "R4", "R4", "R5", "R3", "R5", "R3"};

    function automatic int kind_now();
        if (!res_valid) return (res_hit || res_miss || res_fault) ? 4 : K_NONE;
        if (res_hit && !res_miss && !res_fault) return K_HIT;
        if (res_fault && !res_hit && !res_miss) return K_FLT;
        if (res_miss && !res_hit && !res_fault) return K_MISS;
        return 4;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic u, input logic w, input logic fl);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_user = u; lk_write = w; base_wr = fl;
        @(negedge clk);
        lk_valid = 1'b0; base_wr = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [31:0] va, input logic u,
                              input logic w, input int k, input logic [31:0] pa);
        look(va, u, w, 1'b0);
        check(req, 32'(kind_now()), 32'(k));
        if (k == K_HIT) check(req, res_paddr, pa);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic big,
                        input logic u, input logic w, input logic fl);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        fill_big = big; fill_usr = u; fill_wr = w; base_wr = fl;
        @(negedge clk);
        fill_valid = 1'b0; base_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdy", 32'(rdy), 32'd1);
        check("R1 res_valid", 32'(res_valid), 32'd0);
        // R1/R6: first lookup misses and waits
        expect_res("R1 first miss", 32'h12345ABC, 1'b0, 1'b0, K_MISS, 0);
        check("R6 rdy in wait", 32'(rdy), 32'd0);
        expect_res("R6 lookup ignored in wait", 32'h12345ABC, 1'b0, 1'b0, K_NONE, 0);
        fill(20'h12345, 20'hABCDE, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R6 walk_done", 32'(rdy), 32'd1);
        // remaining slots; large page with junk low bits (R4)
        fill(20'h301FF, 20'h155AA, 1'b1, 1'b0, 1'b1, 1'b0);
        fill(20'h00400, 20'h00777, 1'b0, 1'b1, 1'b0, 1'b0);
        fill(20'hFFFFF, 20'h00001, 1'b0, 1'b1, 1'b1, 1'b0);

        // Table pass: R2 single flag, R3/R4 address, R5 permissions
        for (int i = 0; i < 8; i++) begin
            expect_res(T_REQ[i], T_VA[i], T_USR[i], T_WR[i], T_K[i], T_PA[i]);
            check("R5 rdy kept", 32'(rdy), 32'd1);
        end
        @(negedge clk);
        check("R2 one-cycle result", 32'(res_valid), 32'd0);

        // R9: full cache, round robin from slot 0
        fill(20'h11111, 20'h22222, 1'b0, 1'b1, 1'b1, 1'b0);        // slot0
        expect_res("R9 new entry", 32'h11111234, 1'b1, 1'b0, K_HIT, 32'h22222234);
        expect_res("R9 slot0 evicted", 32'h12345000, 1'b0, 1'b0, K_MISS, 0);
        fill(20'h12345, 20'hABCDE, 1'b0, 1'b1, 1'b1, 1'b0);        // slot1
        expect_res("R9 slot1 evicted", 32'h30000000, 1'b0, 1'b0, K_MISS, 0);
        fill(20'h30000, 20'h155AA, 1'b1, 1'b0, 1'b1, 1'b0);        // slot2
        expect_res("R9 slot2 evicted", 32'h00400123, 1'b0, 1'b0, K_MISS, 0);
        fill(20'h00400, 20'h00777, 1'b0, 1'b1, 1'b0, 1'b0);        // slot3
        expect_res("R9 slot3 evicted", 32'hFFFFF000, 1'b0, 1'b0, K_MISS, 0);
        fill(20'hFFFFF, 20'h00001, 1'b0, 1'b1, 1'b1, 1'b0);        // slot0 again
        expect_res("R9 wrap evicts slot0", 32'h11111000, 1'b0, 1'b0, K_MISS, 0);
        fill(20'h11111, 20'h22222, 1'b0, 1'b1, 1'b1, 1'b0);        // slot1
        expect_res("R9 slot3 kept", 32'h00400123, 1'b0, 1'b0, K_HIT, 32'h00777123);
        expect_res("R9 large kept", 32'h30000010, 1'b0, 1'b0, K_HIT, 32'h15400010);

        // R7: flush alone
        @(negedge clk); base_wr = 1'b1;
        @(negedge clk); base_wr = 1'b0;
        expect_res("R7 flush drops", 32'h00400123, 1'b0, 1'b0, K_MISS, 0);
        fill(20'h00400, 20'h00777, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_res("R7 refill hit", 32'h00400123, 1'b0, 1'b0, K_HIT, 32'h00777123);
        // R7: flush with lookup
        look(32'h00400123, 1'b0, 1'b0, 1'b1);
        check("R7 same-cycle miss", 32'(kind_now()), 32'(K_MISS));
        // R8: flush with fill, fill discarded but walk completes
        fill(20'h00400, 20'h00777, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R8 walk_done on dropped fill", 32'(rdy), 32'd1);
        expect_res("R8 fill discarded", 32'h00400123, 1'b0, 1'b0, K_MISS, 0);
        fill(20'h00400, 20'h00777, 1'b0, 1'b1, 1'b0, 1'b0);        // slot0
        // R9: invalid first, pointer back at 0 after flush
        fill(20'hA0000, 20'h0A000, 1'b0, 1'b1, 1'b1, 1'b0);        // slot1
        fill(20'hB0000, 20'h0B000, 1'b0, 1'b1, 1'b1, 1'b0);        // slot2
        fill(20'hC0000, 20'h0C000, 1'b0, 1'b1, 1'b1, 1'b0);        // slot3
        expect_res("R9 invalid slots used first", 32'h00400123, 1'b0, 1'b0, K_HIT, 32'h00777123);
        fill(20'hD0000, 20'h0D000, 1'b0, 1'b1, 1'b1, 1'b0);        // slot0
        expect_res("R9 ptr reset by flush", 32'h00400123, 1'b0, 1'b0, K_MISS, 0);
        fill(20'h00400, 20'h00777, 1'b0, 1'b1, 1'b0, 1'b0);        // slot1
        expect_res("R9 slot2 kept", 32'hB0000555, 1'b1, 1'b1, K_HIT, 32'h0B000555);
        expect_res("R9 slot0 new", 32'hD0000001, 1'b1, 1'b0, K_HIT, 32'h0D000001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule